// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block loads a configuration image into a target programmable device through an 8-bit parallel pin port. The target is wired for slave-serial loading. The block has four stages, and it advances the port by one word per port tick:

1. It sends a fixed pattern that stops the target's running logic.
2. It pulses the program line while it holds the configuration clock at its idle level. That idle level is high, because the wiring inverts the clock.
3. It polls the target's init-done sense line. It makes a bounded number of tries, with a fixed wait between them.
4. It shifts the image out, most significant bit first. Each bit becomes two port words.

A divider derives the port tick from the system clock. The default setting gives roughly 750 kHz from 50 MHz.

Image bytes arrive on a valid/ready stream, and the last byte is flagged. `s_ready` is high only when all of these hold: the block is in the shift stage, no byte is held, and the flagged last byte has not yet been accepted. A byte is transferred on a clock edge where `s_valid` and `s_ready` are both high. While `s_valid` is high and `s_ready` is low, the source must hold `s_data` and `s_last` steady. If the source starves the block, the port simply holds its last word. The configuration clock then stays paused until the next byte arrives. Control and status are plain level signals: a start strobe, a busy flag, and sticky done and error flags.

Top module: `slave_serial_loader`

## Requirements
- R1: After reset, `pin_out` is 0x00, `pin_dir` is 0x00, `busy`, `done` and `error` are low, and `s_ready` is low. Whenever the block is idle, `pin_out` is 0x00.
- R2: A start accepted while idle begins a run. The first port word appears CLK_DIV clock cycles after the start edge, and each later word follows CLK_DIV cycles after the one before it. `pin_out` changes only on these ticks. The first 16 words are 0x84, 0x84, 0x88, 0x84, 0x88, 0x84, 0x88, 0x84, and then the same eight again. Bit 7 is high throughout, and bit 2 or bit 3 alternates.
- R3: The next 10 words are 0x01, 0x03, 0x03 and then 0x01 seven times. Bit 0 is the configuration clock and is held high (idle). Bit 1 is the program line.
- R4: On the tick after the last program word, `init_in` is sampled after a SYNC_STAGES-flop synchroniser. If it is high, the shift stage starts. If it is low, the block waits INIT_WAIT ticks and samples again. The port holds 0x01 throughout the polling.
- R5: If INIT_TRIES samples in a row read low, the run ends on the tick of the last failing sample: `error` goes high, `busy` goes low and `pin_out` returns to 0x00.
- R6: Each image byte is sent most significant bit first. Each bit d produces two words: first (d<<6)|0x01, then (d<<6). Bit 6 is the data line.
- R7: `s_ready` is low outside the shift stage and while a byte is held. Bytes are accepted in order, and `s_last` marks the final byte.
- R8: On the tick after the final byte's last word, `pin_out` becomes 0x00, `done` goes high and `busy` goes low. `done` and `error` are never high together.
- R9: A start strobe while `busy` is high has no effect on the port sequence.
- R10: `pin_dir` is 0xDF while busy and 0x00 while idle. Every pin except bit 5 (the init sense) is then an output, and bit 5 of `pin_out` is always 0.
- R11: Accepting a new start clears `done` and `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; only acted on while idle |
| init_in | input | 1 | Init-done sense from the target, asynchronous |
| s_valid | input | 1 | Image byte valid |
| s_data | input | 8 | Image byte |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Block accepts an image byte |
| pin_out | output | 8 | Parallel pin port word |
| pin_dir | output | 8 | Pin direction mask, 1 = output |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed, sticky until next start |
| error | output | 1 | Last run found no init-done, sticky until next start |

## Verification
The assertions rely on two properties of the inputs. First, the byte source obeys the stream rule: once `s_valid` is high without `s_ready`, it keeps `s_valid`, `s_data` and `s_last` steady until the transfer. Second, `init_in` stays steady for at least SYNC_STAGES cycles before a poll tick. The stimulus offers each byte at a falling edge and changes it only after it sees the accepting edge. It changes `init_in` only between runs, or several ticks before the next poll. Start strobes during a run are timed so that they never coincide with the end of the run.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

  // Pin positions on the parallel port.
  localparam int PIN_CCLK  = 0;
  localparam int PIN_PROG  = 1;
  localparam int PIN_KA    = 2;
  localparam int PIN_KB    = 3;
  localparam int PIN_SENSE = 5;
  localparam int PIN_DIN   = 6;
  localparam int PIN_KH    = 7;
  localparam int PORT_W    = 8;

  localparam logic [PORT_W-1:0] DIR_MASK = ~(PORT_W'(1) << PIN_SENSE);

  // Sequence lengths.
  localparam int KILL_LEN    = 8;
  localparam int KILL_ROUNDS = 2;
  localparam int PULSE_LEN   = 10;
  localparam int PULSE_FIRST = 1;
  localparam int PULSE_LAST  = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_KILL,
    PH_PULSE,
    PH_POLL,
    PH_SHIFT
  } phase_t;

  // Stop pattern: hold line always high, first and odd slots use line A, other even slots use line B.
  function automatic logic [PORT_W-1:0] kill_word(input logic [2:0] idx);
    logic [PORT_W-1:0] w;
    w = '0;
    w[PIN_KH] = 1'b1;
    if (idx != 3'd0 && !idx[0]) w[PIN_KB] = 1'b1;
    else                        w[PIN_KA] = 1'b1;
    return w;
  endfunction

  // Program pulse: clock idles high, program line raised in a short window.
  function automatic logic [PORT_W-1:0] pulse_word(input int idx);
    logic [PORT_W-1:0] w;
    w = '0;
    w[PIN_CCLK] = 1'b1;
    if (idx >= PULSE_FIRST && idx <= PULSE_LAST) w[PIN_PROG] = 1'b1;
    return w;
  endfunction

  function automatic logic [PORT_W-1:0] bit_word(input logic d, input logic clk_hi);
    logic [PORT_W-1:0] w;
    w = '0;
    w[PIN_DIN]  = d;
    w[PIN_CCLK] = clk_hi;
    return w;
  endfunction

endpackage

// File: rtl/ssl_tick.sv
module ssl_tick #(
  parameter int DIV = 67
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!run || cnt == LAST)   cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R2

endmodule

// File: rtl/ssl_sync.sv
module ssl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ssl_shift.sv
module ssl_shift
  import ssl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              enable,
  input  logic              step,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic [PORT_W-1:0] word,
  output logic              fire,
  output logic              finished
);
  localparam int NB_W = $clog2(DATA_W);
  localparam logic [NB_W-1:0] NB_LAST = NB_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [NB_W-1:0]   nbit;
  logic              hold;
  logic              second;
  logic              last_q;

  assign s_ready = enable && !hold && !finished;
  assign word    = bit_word(sh[DATA_W-1], !second);
  assign fire    = step && hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      nbit     <= '0;
      hold     <= 1'b0;
      second   <= 1'b0;
      last_q   <= 1'b0;
      finished <= 1'b0;
    end else if (clear) begin
      nbit     <= '0;
      hold     <= 1'b0;
      second   <= 1'b0;
      last_q   <= 1'b0;
      finished <= 1'b0;
    end else if (s_valid && s_ready) begin
      sh     <= s_data;
      hold   <= 1'b1;
      second <= 1'b0;
      nbit   <= '0;
      last_q <= s_last;
    end else if (fire) begin
      second <= !second;
      if (second) begin
        sh   <= sh << 1;
        nbit <= nbit + 1'b1;
        if (nbit == NB_LAST) begin
          hold     <= 1'b0;
          finished <= last_q;
        end
      end
    end
  end

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && s_valid && !s_ready && !finished) |=> (s_valid && $stable(s_data) && $stable(s_last))); // R7

  AST_WORD_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !step && !clear) |=> ($stable(sh) && $stable(second))); // R6

endmodule

// File: rtl/ssl_ctrl.sv
module ssl_ctrl
  import ssl_pkg::*;
#(
  parameter int INIT_TRIES = 10,
  parameter int INIT_WAIT  = 7500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic              sense_ok,
  input  logic [PORT_W-1:0] shift_word,
  input  logic              shift_fire,
  input  logic              shift_finished,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              shift_en,
  output logic              shift_clear,
  output logic [PORT_W-1:0] pin_out
);
  localparam int KILL_WORDS = KILL_LEN * KILL_ROUNDS;
  localparam int IDX_MAX    = (KILL_WORDS > PULSE_LEN) ? KILL_WORDS : PULSE_LEN;
  localparam int IDX_W      = $clog2(IDX_MAX);
  localparam int TRY_W      = (INIT_TRIES > 1) ? $clog2(INIT_TRIES) : 1;
  localparam int WAIT_W     = $clog2(INIT_WAIT + 1);

  localparam logic [IDX_W-1:0]  KILL_END  = IDX_W'(KILL_WORDS - 1);
  localparam logic [IDX_W-1:0]  PULSE_END = IDX_W'(PULSE_LEN - 1);
  localparam logic [TRY_W-1:0]  TRY_END   = TRY_W'(INIT_TRIES - 1);
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(INIT_WAIT);

  phase_t            ph;
  logic [IDX_W-1:0]  idx;
  logic [TRY_W-1:0]  tries;
  logic [WAIT_W-1:0] wait_cnt;

  assign busy        = (ph != PH_IDLE);
  assign shift_en    = (ph == PH_SHIFT);
  assign shift_clear = (ph == PH_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      idx      <= '0;
      tries    <= '0;
      wait_cnt <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
      pin_out  <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph    <= PH_KILL;
            idx   <= '0;
            done  <= 1'b0;
            error <= 1'b0;
          end
        end
        PH_KILL: begin
          if (tick) begin
            pin_out <= kill_word(idx[2:0]);
            if (idx == KILL_END) begin
              ph  <= PH_PULSE;
              idx <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        PH_PULSE: begin
          if (tick) begin
            pin_out <= pulse_word(int'(idx));
            if (idx == PULSE_END) begin
              ph       <= PH_POLL;
              idx      <= '0;
              tries    <= '0;
              wait_cnt <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        PH_POLL: begin
          if (tick) begin
            if (wait_cnt != '0) begin
              wait_cnt <= wait_cnt - 1'b1;
            end else if (sense_ok) begin
              ph <= PH_SHIFT;
            end else if (tries == TRY_END) begin
              ph      <= PH_IDLE;
              error   <= 1'b1;
              pin_out <= '0;
            end else begin
              tries    <= tries + 1'b1;
              wait_cnt <= WAIT_LOAD;
            end
          end
        end
        PH_SHIFT: begin
          if (tick) begin
            if (shift_fire) begin
              pin_out <= shift_word;
            end else if (shift_finished) begin
              ph      <= PH_IDLE;
              done    <= 1'b1;
              pin_out <= '0;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_IDLE_PORT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pin_out == '0)); // R1

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R8

  AST_RUN_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !error)); // R11

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !tick) |=> (busy && $stable(pin_out))); // R9

  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_POLL) |-> (tries <= TRY_END)); // R5

endmodule

// File: rtl/slave_serial_loader.sv
module slave_serial_loader
  import ssl_pkg::*;
#(
  parameter int CLK_DIV     = 67,
  parameter int INIT_TRIES  = 10,
  parameter int INIT_WAIT   = 7500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       init_in,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic [7:0] pin_out,
  output logic [7:0] pin_dir,
  output logic       busy,
  output logic       done,
  output logic       error
);
  logic              tick;
  logic              sense_ok;
  logic              shift_en;
  logic              shift_clear;
  logic              shift_fire;
  logic              shift_finished;
  logic [PORT_W-1:0] shift_word;

  ssl_tick #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  ssl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (init_in),
    .q    (sense_ok)
  );

  ssl_shift #(.DATA_W(8)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (shift_clear),
    .enable  (shift_en),
    .step    (tick),
    .s_valid (s_valid),
    .s_data  (s_data),
    .s_last  (s_last),
    .s_ready (s_ready),
    .word    (shift_word),
    .fire    (shift_fire),
    .finished(shift_finished)
  );

  ssl_ctrl #(.INIT_TRIES(INIT_TRIES), .INIT_WAIT(INIT_WAIT)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .tick          (tick),
    .sense_ok      (sense_ok),
    .shift_word    (shift_word),
    .shift_fire    (shift_fire),
    .shift_finished(shift_finished),
    .busy          (busy),
    .done          (done),
    .error         (error),
    .shift_en      (shift_en),
    .shift_clear   (shift_clear),
    .pin_out       (pin_out)
  );

  assign pin_dir = busy ? DIR_MASK : '0;

  AST_PORT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pin_out)); // R2

  AST_SENSE_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out[PIN_SENSE] == 1'b0); // R10

  AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy); // R7

endmodule

// File: tb/slave_serial_loader_bench.sv
module slave_serial_loader_bench;
  localparam int DIV   = 3;
  localparam int TRIES = 3;
  localparam int WAITT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       init_in = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic [7:0] pin_out;
  logic [7:0] pin_dir;
  logic       busy;
  logic       done;
  logic       error;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] pat [0:255];
  logic [7:0] kill_exp [0:7];

  always #10 clk = ~clk;

  slave_serial_loader #(
    .CLK_DIV(DIV), .INIT_TRIES(TRIES), .INIT_WAIT(WAITT), .SYNC_STAGES(2)
  ) u_slave_serial_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .init_in(init_in),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .pin_out(pin_out), .pin_dir(pin_dir), .busy(busy), .done(done), .error(error)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic next_word();
    repeat (DIV) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1;
      s_data  = pat[i];
      s_last  = (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic run_frame(input int n, input bit late, input bit fail_init);
    init_in = !(late || fail_init);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R11 flags cleared by start", {30'd0, done, error}, 32'd0);
    chk("R2 busy after start", {31'd0, busy}, 32'd1);
    if (!fail_init) begin
      fork
        feed(n);
      join_none
    end
    for (int k = 0; k < 16; k++) begin
      next_word();
      chk("R2 stop pattern word", {24'd0, pin_out}, {24'd0, kill_exp[k % 8]});
      if (k == 0) begin
        chk("R10 direction mask busy", {24'd0, pin_dir}, 32'hDF);
        chk("R7 no ready before shift", {31'd0, s_ready}, 32'd0);
      end
    end
    for (int k = 0; k < 10; k++) begin
      next_word();
      chk("R3 program pulse word", {24'd0, pin_out}, (k == 1 || k == 2) ? 32'h03 : 32'h01);
    end
    if (fail_init) begin
      for (int k = 0; k < (TRIES - 1) * (WAITT + 1); k++) begin
        next_word();
        chk("R5 still polling", {23'd0, busy, pin_out}, 32'h101);
      end
      next_word();
      chk("R5 error raised", {29'd0, error, busy, done}, 32'h4);
      chk("R5 port released", {24'd0, pin_out}, 32'd0);
      return;
    end
    for (int k = 0; k < (late ? WAITT + 2 : 1); k++) begin
      next_word();
      chk("R4 port held while polling", {23'd0, busy, pin_out}, 32'h101);
      if (late && k == 0) init_in = 1'b1;
    end
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (b == 1 && i == 4) begin
          fork
            begin
              start = 1'b1;
              @(posedge clk);
              #1 start = 1'b0;
            end
          join_none
        end
        next_word();
        chk((b == 1 && i == 3) ? "R9 start ignored" : "R6 bit word high",
            {24'd0, pin_out}, {24'd0, 1'b0, pat[b][i], 6'b000001});
        next_word();
        chk("R6 bit word low", {24'd0, pin_out}, {24'd0, 1'b0, pat[b][i], 6'b000000});
      end
    end
    next_word();
    chk("R8 done after last word", {29'd0, done, busy, error}, 32'h4);
    chk("R8 port zero at end", {24'd0, pin_out}, 32'd0);
    chk("R10 direction mask idle", {24'd0, pin_dir}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    kill_exp[0] = 8'h84; kill_exp[1] = 8'h84; kill_exp[2] = 8'h88; kill_exp[3] = 8'h84;
    kill_exp[4] = 8'h88; kill_exp[5] = 8'h84; kill_exp[6] = 8'h88; kill_exp[7] = 8'h84;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset port", {16'd0, pin_out, pin_dir}, 32'd0);
    chk("R1 reset flags", {28'd0, busy, done, error, s_ready}, 32'd0);

    pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5; pat[3] = 8'h5A;
    run_frame(4, 1'b0, 1'b0);

    for (int i = 0; i < 256; i++) pat[i] = 8'(i);
    run_frame(256, 1'b1, 1'b0);

    run_frame(1, 1'b0, 1'b1);

    pat[0] = 8'h81;
    run_frame(1, 1'b0, 1'b0);

    repeat (5) @(negedge clk);
    chk("R1 idle port low", {24'd0, pin_out}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule